// File: doc/BRIEF.md
# Chip Erase Sequencer

This block is a host-side controller that carries out a full, verified chip erase on a word-wide flash memory. It drives the memory through a simple synchronous bus master port. When `start` is pulsed, the controller raises the programming-supply enable and then programs every word to zero. It then issues erase pulses and checks the array word by word until every word reads back as all ones.

Verification resumes at the first word that failed and does not rescan words that already passed. A bounded budget of failed checks ends the run with an error. All wait times, the array depth and the retry budget are parameters counted in clock cycles. The block reports completion through sticky `done` and `error` flags.

Top module: `chip_erase_seq`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `vpp_en`, `bus_wr` and `bus_rd` are all low, and no bus strobe is issued until `start` is seen.
- R2: `vpp_en` rises in the cycle after `start` is accepted, before the first bus write. It is high during every bus write and read. It falls in the same cycle that `done` or `error` rises.
- R3: Pre-programming visits addresses 0 to DEPTH-1 in ascending order. For each address it writes 0040h and then 0000h to that address, and it waits at least PROG_WAIT cycles before the next bus write.
- R4: After pre-programming, the address and the failure count restart at zero. Each erase pulse is two back-to-back writes of 0020h at the current address, followed by at least ERASE_WAIT cycles with no bus activity.
- R5: A word check writes 00A0h at the word's address and waits at least VERIFY_WAIT cycles. It then issues a single read strobe at the same address. `bus_rdata` is sampled in the second cycle after the strobe.
- R6: A word that reads FFFFh advances the check to the next address without a new erase pulse. After a failed check and a new pulse, checking resumes at the failing address and does not revisit lower addresses.
- R7: A word that reads anything other than FFFFh counts as a failure and triggers a new erase pulse. Once MAX_PULSES failures have occurred, the controller sets `error`, does not set `done`, and makes no further bus access. A run that needs exactly MAX_PULSES pulses still succeeds.
- R8: When the word at address DEPTH-1 passes, the controller writes 0000h at that address and then sets `done`.
- R9: `done` and `error` stay set until the next accepted `start`, which clears both. A `start` pulse while `busy` is high has no effect on the bus sequence.
- R10: `bus_wr` and `bus_rd` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to begin a chip erase |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sticky: erase finished and verified |
| error | output | 1 | Sticky: failure budget exhausted |
| vpp_en | output | 1 | Programming-supply enable |
| bus_addr | output | ADDR_W | Memory word address |
| bus_wdata | output | DATA_W | Write data / command code |
| bus_wr | output | 1 | Write strobe, one cycle per write |
| bus_rd | output | 1 | Read strobe, one cycle per read |
| bus_rdata | input | DATA_W | Read data, valid one cycle after `bus_rd` |

## Verification
The hardest situation to reach from the ports is a retry that resumes in the middle of the array after earlier words passed, together with its edge case of exhausting the failure budget exactly at its limit. The bench memory model is therefore loaded, for each run, with the number of erase pulses each word needs before it reads all ones. With uneven per-word needs, the controller is forced to fail in the middle of the array, pulse again and resume there. Need sets chosen to reach exactly MAX_PULSES, or one more, drive the sequence onto the success boundary and onto the error path.

// File: rtl/ces_pkg.sv
package ces_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PWR,
        S_PP_SETUP,
        S_PP_DATA,
        S_PP_WAIT,
        S_ER_ARM,
        S_ER_FIRE,
        S_ER_WAIT,
        S_EV_CMD,
        S_EV_WAIT,
        S_EV_READ,
        S_EV_HOLD,
        S_EV_CHECK,
        S_RD_MODE,
        S_CLOSE
    } ces_state_e;

    localparam logic [7:0] OP_PROGRAM = 8'h40;
    localparam logic [7:0] OP_ERASE   = 8'h20;
    localparam logic [7:0] OP_EVERIFY = 8'hA0;
    localparam logic [7:0] OP_READ    = 8'h00;

endpackage

// File: rtl/ces_wait_timer.sv
module ces_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             busy
);
    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.run = (len != '0);
            tmr_d.cnt = len;
        end else if (tmr_q.run) begin
            if (tmr_q.cnt <= CNT_W'(1)) begin
                tmr_d.run = 1'b0;
                tmr_d.cnt = '0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy = tmr_q.run;

    // R4 / R5: a nonzero load always produces a waiting interval
    a_r5_timer_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (load && len != '0) |=> busy);

endmodule

// File: rtl/ces_progress.sv
module ces_progress #(
    parameter int ADDR_W     = 16,
    parameter int MAX_PULSES = 1000,
    localparam int PC_W      = $clog2(MAX_PULSES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv_addr,
    input  logic              bump_fail,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last,
    output logic              budget_spent
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [PC_W-1:0]   fails;
    } prog_t;

    prog_t prg_d, prg_q;

    always_comb begin
        prg_d = prg_q;
        if (clr) begin
            prg_d = '0;
        end else begin
            if (adv_addr)  prg_d.addr  = prg_q.addr + ADDR_W'(1);
            if (bump_fail) prg_d.fails = prg_q.fails + PC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prg_q <= '0;
        else        prg_q <= prg_d;
    end

    assign addr         = prg_q.addr;
    assign at_last      = (prg_q.addr == {ADDR_W{1'b1}});
    assign budget_spent = (prg_q.fails == PC_W'(MAX_PULSES - 1));

    // R7: the sequencer never counts a failure past the budget
    a_r7_bump_within_budget: assert property (@(posedge clk) disable iff (!rst_n)
        bump_fail |-> !budget_spent);

    // R6: the address never advances beyond the final word
    a_r6_adv_not_past_end: assert property (@(posedge clk) disable iff (!rst_n)
        adv_addr |-> !at_last);

endmodule

// File: rtl/chip_erase_seq.sv
module chip_erase_seq
    import ces_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int PROG_WAIT   = 500,
    parameter int ERASE_WAIT  = 500000,
    parameter int VERIFY_WAIT = 300,
    parameter int MAX_PULSES  = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic              vpp_en,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int WMAX_PV = (PROG_WAIT > VERIFY_WAIT) ? PROG_WAIT : VERIFY_WAIT;
    localparam int WMAX    = (ERASE_WAIT > WMAX_PV) ? ERASE_WAIT : WMAX_PV;
    localparam int TW      = $clog2(WMAX + 1);

    typedef struct packed {
        ces_state_e        st;
        logic              vpp;
        logic              done;
        logic              err;
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              tmr_load, tmr_busy;
    logic [TW-1:0]     tmr_len;
    logic              trk_clr, trk_adv, trk_bump;
    logic [ADDR_W-1:0] trk_addr;
    logic              trk_last, trk_spent;

    function automatic logic [DATA_W-1:0] op(input logic [7:0] code);
        return {{(DATA_W-8){1'b0}}, code};
    endfunction

    ces_wait_timer #(.CNT_W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .len   (tmr_len),
        .busy  (tmr_busy)
    );

    ces_progress #(.ADDR_W(ADDR_W), .MAX_PULSES(MAX_PULSES)) u_prog (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (trk_clr),
        .adv_addr     (trk_adv),
        .bump_fail    (trk_bump),
        .addr         (trk_addr),
        .at_last      (trk_last),
        .budget_spent (trk_spent)
    );

    always_comb begin
        seq_d    = seq_q;
        seq_d.wr = 1'b0;
        seq_d.rd = 1'b0;
        tmr_load = 1'b0;
        tmr_len  = '0;
        trk_clr  = 1'b0;
        trk_adv  = 1'b0;
        trk_bump = 1'b0;
        unique case (seq_q.st)
            S_IDLE: if (start) begin
                seq_d.st   = S_PWR;
                seq_d.vpp  = 1'b1;
                seq_d.done = 1'b0;
                seq_d.err  = 1'b0;
                trk_clr    = 1'b1;
            end
            S_PWR: seq_d.st = S_PP_SETUP;
            S_PP_SETUP: begin
                seq_d.wr    = 1'b1;
                seq_d.addr  = trk_addr;
                seq_d.wdata = op(OP_PROGRAM);
                seq_d.st    = S_PP_DATA;
            end
            S_PP_DATA: begin
                seq_d.wr    = 1'b1;
                seq_d.addr  = trk_addr;
                seq_d.wdata = '0;
                tmr_load    = 1'b1;
                tmr_len     = TW'(PROG_WAIT);
                seq_d.st    = S_PP_WAIT;
            end
            S_PP_WAIT: if (!tmr_busy) begin
                if (trk_last) begin
                    trk_clr  = 1'b1;
                    seq_d.st = S_ER_ARM;
                end else begin
                    trk_adv  = 1'b1;
                    seq_d.st = S_PP_SETUP;
                end
            end
            S_ER_ARM, S_ER_FIRE: begin
                seq_d.wr    = 1'b1;
                seq_d.addr  = trk_addr;
                seq_d.wdata = op(OP_ERASE);
                if (seq_q.st == S_ER_FIRE) begin
                    tmr_load = 1'b1;
                    tmr_len  = TW'(ERASE_WAIT);
                    seq_d.st = S_ER_WAIT;
                end else begin
                    seq_d.st = S_ER_FIRE;
                end
            end
            S_ER_WAIT: if (!tmr_busy) seq_d.st = S_EV_CMD;
            S_EV_CMD: begin
                seq_d.wr    = 1'b1;
                seq_d.addr  = trk_addr;
                seq_d.wdata = op(OP_EVERIFY);
                tmr_load    = 1'b1;
                tmr_len     = TW'(VERIFY_WAIT);
                seq_d.st    = S_EV_WAIT;
            end
            S_EV_WAIT: if (!tmr_busy) seq_d.st = S_EV_READ;
            S_EV_READ: begin
                seq_d.rd   = 1'b1;
                seq_d.addr = trk_addr;
                seq_d.st   = S_EV_HOLD;
            end
            S_EV_HOLD: seq_d.st = S_EV_CHECK;
            S_EV_CHECK: begin
                if (&bus_rdata) begin
                    if (trk_last) begin
                        seq_d.st = S_RD_MODE;
                    end else begin
                        trk_adv  = 1'b1;
                        seq_d.st = S_EV_CMD;
                    end
                end else if (trk_spent) begin
                    seq_d.err = 1'b1;
                    seq_d.vpp = 1'b0;
                    seq_d.st  = S_IDLE;
                end else begin
                    trk_bump = 1'b1;
                    seq_d.st = S_ER_ARM;
                end
            end
            S_RD_MODE: begin
                seq_d.wr    = 1'b1;
                seq_d.addr  = trk_addr;
                seq_d.wdata = op(OP_READ);
                seq_d.st    = S_CLOSE;
            end
            S_CLOSE: begin
                seq_d.done = 1'b1;
                seq_d.vpp  = 1'b0;
                seq_d.st   = S_IDLE;
            end
            default: seq_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: S_IDLE, default: '0};
        else        seq_q <= seq_d;
    end

    assign busy      = (seq_q.st != S_IDLE);
    assign done      = seq_q.done;
    assign error     = seq_q.err;
    assign vpp_en    = seq_q.vpp;
    assign bus_addr  = seq_q.addr;
    assign bus_wdata = seq_q.wdata;
    assign bus_wr    = seq_q.wr;
    assign bus_rd    = seq_q.rd;

    a_r2_access_under_vpp: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr || bus_rd) |-> vpp_en);

    a_r2_vpp_drops_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vpp_en) |-> (done || error));

    a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

    a_r7_quiet_after_error: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (!bus_wr && !bus_rd && !done));

    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    a_r9_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> error);

    a_r4_erase_wait_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == S_ER_WAIT && tmr_busy) |=> (!bus_wr && !bus_rd));

endmodule

// File: tb/sim_chip_erase_seq.sv
module sim_chip_erase_seq;
    localparam int AW = 3;
    localparam int DW = 16;
    localparam int D  = 1 << AW;
    localparam int PW = 3;
    localparam int EW = 10;
    localparam int VW = 2;
    localparam int MP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          busy, done, error, vpp_en, bus_wr, bus_rd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;

    always #10 clk = ~clk;

    chip_erase_seq #(
        .ADDR_W(AW), .DATA_W(DW), .PROG_WAIT(PW), .ERASE_WAIT(EW),
        .VERIFY_WAIT(VW), .MAX_PULSES(MP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .error(error), .vpp_en(vpp_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory model: each word reads all ones once enough erase pulses arrived
    int need [D];
    int pulse_ct = 0;
    bit half = 1'b0;

    always @(posedge clk) begin
        if (bus_wr) begin
            if (bus_wdata == 16'h0020) begin
                if (half) begin pulse_ct <= pulse_ct + 1; half <= 1'b0; end
                else half <= 1'b1;
            end else half <= 1'b0;
        end
        if (bus_rd) bus_rdata <= (pulse_ct >= need[bus_addr]) ? 16'hFFFF : 16'h0000;
    end

    // scoreboard
    typedef logic [AW+DW:0] item_t;
    item_t exp_q[$];

    function automatic item_t mk(input bit rd, input int a, input logic [DW-1:0] d);
        return {rd, AW'(a), d};
    endfunction

    task automatic push_expected(output bit want_err);
        int a = 0;
        int fails = 0;
        int pulses = 0;
        bit fin = 1'b0;
        want_err = 1'b0;
        for (int i = 0; i < D; i++) begin
            exp_q.push_back(mk(0, i, 16'h0040));
            exp_q.push_back(mk(0, i, 16'h0000));
        end
        while (!fin) begin
            exp_q.push_back(mk(0, a, 16'h0020));
            exp_q.push_back(mk(0, a, 16'h0020));
            pulses++;
            while (!fin) begin
                exp_q.push_back(mk(0, a, 16'h00A0));
                exp_q.push_back(mk(1, a, 16'h0000));
                if (pulses >= need[a]) begin
                    if (a == D - 1) begin
                        exp_q.push_back(mk(0, a, 16'h0000));
                        fin = 1'b1;
                    end else a++;
                end else begin
                    fails++;
                    if (fails == MP) begin want_err = 1'b1; fin = 1'b1; end
                    break;
                end
            end
        end
    endtask

    // monitor
    int   cyc = 0;
    int   last_cyc = 0;
    logic [DW-1:0] last_w = '1;
    logic [DW-1:0] prev_w = '1;

    always @(negedge clk) begin
        cyc++;
        if (rst_n && (bus_wr || bus_rd)) begin
            item_t got;
            got = {bus_rd, bus_addr, bus_rd ? 16'h0000 : bus_wdata};
            check(vpp_en, "R2", "vpp_en during access", vpp_en, 1);
            check(!(bus_wr && bus_rd), "R10", "wr and rd together", {bus_wr, bus_rd}, 0);
            if (exp_q.size() == 0) begin
                check(0, "R7", "unexpected bus access", got, 0);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                check(got == e, "R6", "bus transaction", got, e);
            end
            if (bus_wr && bus_wdata == 16'h00A0 && last_w == 16'h0020)
                check(cyc - last_cyc >= EW, "R4", "erase wait", cyc - last_cyc, EW);
            if (bus_rd)
                check(last_w == 16'h00A0 && cyc - last_cyc >= VW, "R5",
                      "verify wait", cyc - last_cyc, VW);
            if (bus_wr && prev_w == 16'h0040)
                check(cyc - last_cyc >= PW, "R3", "program wait", cyc - last_cyc, PW);
            if (bus_wr) begin
                prev_w = last_w;
                last_w = bus_wdata;
            end else begin
                prev_w = '1;
                last_w = '1;
            end
            last_cyc = cyc;
        end
    end

    task automatic run(input string tag, input bit poke_busy);
        bit want_err;
        int t = 0;
        pulse_ct = 0;
        exp_q.delete();
        push_expected(want_err);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && vpp_en && !done && !error, "R9", {tag, " start accepted"},
              {busy, vpp_en, done, error}, 4'b1100);
        while (!(done || error) && t < 20000) begin
            if (poke_busy && t == 40) start = 1'b1;
            if (poke_busy && t == 41) start = 1'b0;
            @(negedge clk);
            t++;
        end
        check(t < 20000, "R8", {tag, " completion"}, t, 0);
        check(error == want_err && done == !want_err,
              want_err ? "R7" : "R8", {tag, " flags"}, {done, error}, {!want_err, want_err});
        check(!vpp_en && !busy, "R2", {tag, " supply released"}, {vpp_en, busy}, 0);
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R6", {tag, " items left"}, exp_q.size(), 0);
        check(done == !want_err && error == want_err, "R9", {tag, " flags held"},
              {done, error}, {!want_err, want_err});
    endtask

    initial begin
        for (int i = 0; i < D; i++) need[i] = 1;
        repeat (3) @(negedge clk);
        check({busy, done, error, vpp_en, bus_wr, bus_rd} == 6'b0, "R1", "in reset",
              {busy, done, error, vpp_en, bus_wr, bus_rd}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check({busy, done, error, vpp_en, bus_wr, bus_rd} == 6'b0, "R1", "idle after reset",
              {busy, done, error, vpp_en, bus_wr, bus_rd}, 0);

        // R3 R4 R8: every word erases after one pulse
        run("single pulse", 1'b0);

        // R6 R7 boundary: resume mid-array, exactly MP pulses, start poked while busy (R9)
        need = '{1, 2, 2, 3, 1, 4, 4, 2};
        run("resume", 1'b1);

        // R7: one word needs more pulses than the budget allows
        need = '{1, 1, 1, 5, 1, 1, 1, 1};
        run("budget", 1'b0);

        // R9: a fresh start after an error clears it and succeeds
        for (int i = 0; i < D; i++) need[i] = (i == 0) ? 2 : 1;
        run("restart", 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(negedge clk);
        n_bad++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule